// File: doc/BRIEF.md
# Tree Pseudo-LRU Replacement Picker with Flush Sweep Mode

This block decides which way of an eight-way set-associative cache set gets replaced on a miss, and keeps the replacement history of every set. Each set owns a binary tree of seven history bits. A replacement request names a set and carries that set's per-way valid bits. One clock later the block returns the chosen way and the history value the set would hold once that way is filled. A separate touch strobe reports each hit or fill. It names the set and the way, and it rewrites the history bits along that way's path in the tree.

In ordinary operation, a way that holds no valid line is always taken before the history tree is consulted. Software can also raise a sweep mode while it evicts the whole cache with a run of loads to distinct 32-byte lines. In that mode the valid bits are disregarded and only the tree decides. Eight fills to a set, with no hits in between, then replace each of the eight ways exactly once.

Top module: `plru_victim_sel`

## Requirements
- R1: After reset every set's history is 7'h00; a request to any set with all ways valid in ordinary mode then returns way 0 with next history 7'h0B.
- R2: victim_vld_o is high in exactly the cycles that follow a cycle with sel_req_i high, and way and history outputs change only then.
- R3: In ordinary mode (flush_assist_i low), if any bit of sel_valid_i is 0, the victim is the lowest-numbered way whose valid bit is 0.
- R4: In ordinary mode with all ways valid, the victim follows the tree: history bit 0 picks the lower (0) or upper (1) half, the chosen child node n (children of node k are 2k+1 and 2k+2) picks the quarter, and its child picks the way; the three bits read form the way number MSB first.
- R5: With flush_assist_i high, sel_valid_i has no effect and the victim is the tree walk of R4.
- R6: A touch (touch_i high) to way w of a set sets each of the three bits on w's path to the opposite of w's bit at that level and leaves the other four bits unchanged; the new history is seen by requests from the next cycle on.
- R7: next_plru_o equals the requested set's history with the R6 update applied for the returned victim way.
- R8: With flush_assist_i high, eight request-then-fill rounds on one set, starting from any history and with no other touches to that set, return each of the eight ways exactly once.
- R9: A touch changes only the history of the set it names.
- R10: A request and a touch to the same set in the same cycle: the request is decided on the history held before that touch.
- R11: With touch_i low, touch_set_i and touch_way_i have no effect on any history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_assist_i | input | 1 | Sweep mode: ignore valid bits, use the tree only |
| sel_req_i | input | 1 | Replacement request strobe |
| sel_set_i | input | 6 | Set index of the request |
| sel_valid_i | input | 8 | Valid bit of each way of the requested set |
| touch_i | input | 1 | Hit or fill strobe |
| touch_set_i | input | 6 | Set index of the touched line |
| touch_way_i | input | 3 | Way that was hit or filled |
| victim_vld_o | output | 1 | Victim outputs carry a new result |
| victim_way_o | output | 3 | Chosen way |
| next_plru_o | output | 7 | Set history after filling the chosen way |

## Verification
The bench aims at the priority between invalid ways and the tree. It uses patterns with a single invalid way at each end, with none invalid, and with all invalid. A picker that scanned from the top, or that let the tree win, would return the wrong way. It runs sweep-mode rounds from both a fresh set and a scrambled one. If invalid priority leaked into sweep mode, or a touch failed to flip a whole path, a way would come back twice. Same-cycle request and touch to one set, idle touch fields with touch_i low, and touches to neighbouring sets expose forwarding that should not exist, writes without an enable, and index aliasing.

// File: rtl/plru_pkg.sv
package plru_pkg;

  // Replacement policy currently in force
  typedef enum logic {
    REPL_NORMAL = 1'b0,
    REPL_SWEEP  = 1'b1
  } repl_mode_e;

  localparam int unsigned PLRU_SETS_DEF = 64;
  localparam int unsigned PLRU_WAYS_DEF = 8;

endpackage

// File: rtl/plru_state_store.sv
// Per-set tree history, cleared on reset; one write port, two read ports.
module plru_state_store #(
  parameter int unsigned NUM_SETS = 64,
  parameter int unsigned NODES    = 7,
  localparam int unsigned SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] rd_a_idx,
  output logic [NODES-1:0] rd_a_data,
  input  logic [SET_W-1:0] rd_b_idx,
  output logic [NODES-1:0] rd_b_data,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_idx,
  input  logic [NODES-1:0] wr_data
);

  logic [NODES-1:0] hist_q [NUM_SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SETS; s++) hist_q[s] <= '0;
    end else if (wr_en) begin
      hist_q[wr_idx] <= wr_data;
    end
  end

  assign rd_a_data = hist_q[rd_a_idx];
  assign rd_b_data = hist_q[rd_b_idx];

endmodule

// File: rtl/plru_tree_walk.sv
// Follows the history bits from the root to a leaf.
module plru_tree_walk #(
  parameter int unsigned NUM_WAYS = 8,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS),
  localparam int unsigned NODES   = NUM_WAYS - 1,
  localparam int unsigned IDX_W   = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic [NODES-1:0] hist,
  output logic [WAY_W-1:0] leaf
);

  logic [IDX_W-1:0] node;
  logic             dir;

  always_comb begin
    node = '0;
    dir  = 1'b0;
    leaf = '0;
    for (int l = 0; l < WAY_W; l++) begin
      dir                = hist[node];
      leaf[WAY_W-1-l]    = dir;
      node               = (node << 1) + IDX_W'(1) + IDX_W'(dir);
    end
  end

endmodule

// File: rtl/plru_tree_touch.sv
// Rewrites the bits on a way's path so that they point away from it.
module plru_tree_touch #(
  parameter int unsigned NUM_WAYS = 8,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS),
  localparam int unsigned NODES   = NUM_WAYS - 1,
  localparam int unsigned IDX_W   = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic [NODES-1:0] hist,
  input  logic [WAY_W-1:0] way,
  output logic [NODES-1:0] hist_nxt
);

  logic [IDX_W-1:0] node;
  logic             dir;

  always_comb begin
    hist_nxt = hist;
    node     = '0;
    dir      = 1'b0;
    for (int l = 0; l < WAY_W; l++) begin
      dir            = way[WAY_W-1-l];
      hist_nxt[node] = ~dir;
      node           = (node << 1) + IDX_W'(1) + IDX_W'(dir);
    end
  end

endmodule

// File: rtl/plru_low_invalid.sv
// Finds the lowest-numbered way whose valid bit is clear.
module plru_low_invalid #(
  parameter int unsigned NUM_WAYS = 8,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0] valid,
  output logic                found,
  output logic [WAY_W-1:0]    idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!valid[w]) begin
        found = 1'b1;
        idx   = WAY_W'(w);
      end
    end
  end

endmodule

// File: rtl/plru_victim_sel.sv
module plru_victim_sel
  import plru_pkg::*;
#(
  parameter int unsigned NUM_SETS = PLRU_SETS_DEF,
  parameter int unsigned NUM_WAYS = PLRU_WAYS_DEF,
  localparam int unsigned SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS),
  localparam int unsigned NODES   = NUM_WAYS - 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush_assist_i,
  input  logic                sel_req_i,
  input  logic [SET_W-1:0]    sel_set_i,
  input  logic [NUM_WAYS-1:0] sel_valid_i,
  input  logic                touch_i,
  input  logic [SET_W-1:0]    touch_set_i,
  input  logic [WAY_W-1:0]    touch_way_i,
  output logic                victim_vld_o,
  output logic [WAY_W-1:0]    victim_way_o,
  output logic [NODES-1:0]    next_plru_o
);

  repl_mode_e       mode;
  logic [NODES-1:0] sel_state;
  logic [NODES-1:0] tch_state;
  logic [NODES-1:0] tch_next;
  logic [WAY_W-1:0] tree_way;
  logic             inv_found;
  logic [WAY_W-1:0] inv_way;
  logic [WAY_W-1:0] pick_way;
  logic [NODES-1:0] pick_next;

  assign mode = flush_assist_i ? REPL_SWEEP : REPL_NORMAL;

  plru_state_store #(.NUM_SETS(NUM_SETS), .NODES(NODES)) u_store (
    .clk       (clk),
    .rst       (rst),
    .rd_a_idx  (sel_set_i),
    .rd_a_data (sel_state),
    .rd_b_idx  (touch_set_i),
    .rd_b_data (tch_state),
    .wr_en     (touch_i),
    .wr_idx    (touch_set_i),
    .wr_data   (tch_next)
  );

  plru_tree_walk #(.NUM_WAYS(NUM_WAYS)) u_walk (
    .hist (sel_state),
    .leaf (tree_way)
  );

  plru_low_invalid #(.NUM_WAYS(NUM_WAYS)) u_inv (
    .valid (sel_valid_i),
    .found (inv_found),
    .idx   (inv_way)
  );

  // Update path for hits and fills
  plru_tree_touch #(.NUM_WAYS(NUM_WAYS)) u_touch_upd (
    .hist     (tch_state),
    .way      (touch_way_i),
    .hist_nxt (tch_next)
  );

  // Preview of the history once the picked way is filled
  plru_tree_touch #(.NUM_WAYS(NUM_WAYS)) u_pick_upd (
    .hist     (sel_state),
    .way      (pick_way),
    .hist_nxt (pick_next)
  );

  always_comb begin
    pick_way = tree_way;
    if (mode == REPL_NORMAL && inv_found) pick_way = inv_way;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      victim_vld_o <= 1'b0;
      victim_way_o <= '0;
      next_plru_o  <= '0;
    end else begin
      victim_vld_o <= sel_req_i;
      if (sel_req_i) begin
        victim_way_o <= pick_way;
        next_plru_o  <= pick_next;
      end
    end
  end

endmodule

// File: rtl/plru_victim_sel_chk.sv
module plru_victim_sel_chk #(
  parameter int unsigned NUM_WAYS = 8,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS),
  localparam int unsigned NODES   = NUM_WAYS - 1
) (
  input logic                clk,
  input logic                rst,
  input logic                flush_assist_i,
  input logic                sel_req_i,
  input logic [NUM_WAYS-1:0] sel_valid_i,
  input logic                victim_vld_o,
  input logic [WAY_W-1:0]    victim_way_o,
  input logic [NODES-1:0]    next_plru_o,
  input logic [NODES-1:0]    sel_state
);

  logic [NUM_WAYS-1:0] valid_q;
  logic                sweep_q;
  logic                root_q;
  logic [NUM_WAYS-1:0] below_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '1;
      sweep_q <= 1'b0;
      root_q  <= 1'b0;
    end else if (sel_req_i) begin
      valid_q <= sel_valid_i;
      sweep_q <= flush_assist_i;
      root_q  <= sel_state[0];
    end
  end

  assign below_mask = (NUM_WAYS'(1) << victim_way_o) - NUM_WAYS'(1);

  AST_VLD_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    sel_req_i |=> victim_vld_o); // R2
  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !sel_req_i |=> !victim_vld_o); // R2
  AST_INVALID_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (victim_vld_o && !sweep_q && !(&valid_q)) |-> !valid_q[victim_way_o]); // R3
  AST_LOWER_ALL_VALID: assert property (@(posedge clk) disable iff (rst)
    (victim_vld_o && !sweep_q && !(&valid_q)) |-> ((valid_q | ~below_mask) == '1)); // R3
  AST_SWEEP_ROOT: assert property (@(posedge clk) disable iff (rst)
    (victim_vld_o && sweep_q) |-> (victim_way_o[WAY_W-1] == root_q)); // R5
  AST_NEXT_POINTS_AWAY: assert property (@(posedge clk) disable iff (rst)
    victim_vld_o |-> (next_plru_o[0] != victim_way_o[WAY_W-1])); // R7

endmodule

bind plru_victim_sel plru_victim_sel_chk #(.NUM_WAYS(NUM_WAYS)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .flush_assist_i (flush_assist_i),
  .sel_req_i      (sel_req_i),
  .sel_valid_i    (sel_valid_i),
  .victim_vld_o   (victim_vld_o),
  .victim_way_o   (victim_way_o),
  .next_plru_o    (next_plru_o),
  .sel_state      (sel_state)
);

// File: tb/plru_victim_sel_tb_top.sv
`timescale 1ns/1ps
module plru_victim_sel_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       flush_assist_i = 1'b0;
  logic       sel_req_i = 1'b0;
  logic [5:0] sel_set_i = '0;
  logic [7:0] sel_valid_i = '1;
  logic       touch_i = 1'b0;
  logic [5:0] touch_set_i = '0;
  logic [2:0] touch_way_i = '0;
  logic       victim_vld_o;
  logic [2:0] victim_way_o;
  logic [6:0] next_plru_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [6:0] model [64];

  always #2 clk = ~clk;

  plru_victim_sel dut_i (
    .clk(clk), .rst(rst), .flush_assist_i(flush_assist_i),
    .sel_req_i(sel_req_i), .sel_set_i(sel_set_i), .sel_valid_i(sel_valid_i),
    .touch_i(touch_i), .touch_set_i(touch_set_i), .touch_way_i(touch_way_i),
    .victim_vld_o(victim_vld_o), .victim_way_o(victim_way_o), .next_plru_o(next_plru_o)
  );

  function automatic logic [2:0] ref_walk(input logic [6:0] h);
    logic a, b, c;
    a = h[0];
    b = a ? h[2] : h[1];
    c = h[3 + 2*int'(a) + int'(b)];
    return {a, b, c};
  endfunction

  function automatic logic [6:0] ref_touch(input logic [6:0] h, input logic [2:0] w);
    logic [6:0] r;
    r = h;
    r[0] = ~w[2];
    r[1 + int'(w[2])] = ~w[1];
    r[3 + 2*int'(w[2]) + int'(w[1])] = ~w[0];
    return r;
  endfunction

  function automatic logic [2:0] ref_pick(input logic [7:0] v, input bit fa, input logic [6:0] h);
    if (!fa) for (int w = 0; w < 8; w++) if (!v[w]) return 3'(w);
    return ref_walk(h);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit sel, input logic [5:0] ss, input logic [7:0] sv, input bit fa,
                      input bit t, input logic [5:0] ts, input logic [2:0] tw,
                      input string req, output logic [2:0] got);
    logic [2:0] ew;
    logic [6:0] en;
    @(negedge clk);
    sel_req_i = sel; sel_set_i = ss; sel_valid_i = sv; flush_assist_i = fa;
    touch_i = t; touch_set_i = ts; touch_way_i = tw;
    ew = ref_pick(sv, fa, model[ss]);   // decided on pre-touch history (R10)
    en = ref_touch(model[ss], ew);
    @(posedge clk);
    #1;
    if (t) model[ts] = ref_touch(model[ts], tw);
    got = victim_way_o;
    if (sel) begin
      chk(victim_vld_o === 1'b1, {req, " vld R2"}, int'(victim_vld_o), 1);
      chk(victim_way_o === ew, {req, " way"}, int'(victim_way_o), int'(ew));
      chk(next_plru_o === en, {req, " next R7"}, int'(next_plru_o), int'(en));
    end else begin
      chk(victim_vld_o === 1'b0, {req, " idle R2"}, int'(victim_vld_o), 0);
    end
  endtask

  task automatic sweep_round(input logic [5:0] s, input string req);
    logic [7:0] seen;
    logic [2:0] w;
    seen = '0;
    for (int i = 0; i < 8; i++) begin
      step(1, s, 8'h00, 1, 0, 0, 0, {req, " R5"}, w);
      seen[w] = 1'b1;
      step(0, 0, 8'hFF, 1, 1, s, w, {req, " fill"}, w);
    end
    chk(seen === 8'hFF, {req, " R8 all ways once"}, int'(seen), 8'hFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] g;
    void'($urandom(32'h5EED_1234));
    for (int s = 0; s < 64; s++) model[s] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(victim_vld_o === 1'b0, "R1 vld low in reset", int'(victim_vld_o), 0);
    rst = 1'b0;

    step(0, 0, 8'hFF, 0, 0, 0, 0, "R1 idle after reset", g);
    step(1, 0, 8'hFF, 0, 0, 0, 0, "R1 fresh set", g);
    chk(g === 3'd0, "R1 way 0", int'(g), 0);
    chk(next_plru_o === 7'h0B, "R1 next 0B", int'(next_plru_o), 8'h0B);

    step(1, 4, 8'b1111_0111, 0, 0, 0, 0, "R3 single hole", g);
    step(1, 4, 8'b0111_1111, 0, 0, 0, 0, "R3 top hole", g);
    step(1, 4, 8'b1111_1110, 0, 0, 0, 0, "R3 bottom hole", g);
    step(1, 4, 8'b0000_0000, 0, 0, 0, 0, "R3 all empty", g);
    step(1, 4, 8'b0101_0100, 0, 0, 0, 0, "R3 many holes", g);

    step(0, 0, 8'hFF, 0, 1, 3, 3'd5, "R6 touch", g);
    step(1, 3, 8'hFF, 0, 0, 0, 0, "R6 R4 after touch", g);
    chk(g === 3'd0, "R6 way 0 after touch 5", int'(g), 0);
    step(1, 3, 8'hFF, 0, 0, 0, 0, "R4 tree walk", g);

    step(0, 0, 8'hFF, 0, 1, 1, 3'd0, "R9 touch set1", g);
    step(1, 2, 8'hFF, 0, 0, 0, 0, "R9 neighbour set2", g);
    chk(g === 3'd0, "R9 set2 unchanged", int'(g), 0);

    step(0, 0, 8'hFF, 0, 0, 0, 3'd7, "R11 idle touch", g);
    step(1, 0, 8'hFF, 0, 0, 0, 0, "R11 set0 unchanged", g);
    chk(next_plru_o === 7'h0B, "R11 set0 history", int'(next_plru_o), 8'h0B);

    step(1, 7, 8'hFF, 0, 1, 7, 3'd0, "R10 same cycle", g);
    chk(g === 3'd0, "R10 pre-touch decision", int'(g), 0);
    step(1, 7, 8'hFF, 0, 0, 0, 0, "R10 R6 post-touch", g);
    chk(g === 3'd4, "R6 post-touch way 4", int'(g), 4);

    step(1, 5, 8'b1111_1110, 1, 0, 0, 0, "R5 valid ignored", g);
    chk(g === 3'd0, "R5 tree not hole", int'(g), 0);
    step(1, 5, 8'hFF, 1, 0, 0, 0, "R5 sweep", g);
    sweep_round(9, "sweep fresh");

    for (int i = 0; i < 4000; i++) begin
      logic [7:0] v;
      v = ($urandom % 2) ? 8'hFF : 8'($urandom);
      step($urandom % 3 != 0, 6'($urandom % 12), v, ($urandom % 4) == 0,
           $urandom % 2, 6'($urandom % 12), 3'($urandom), "R4 random", g);
    end
    sweep_round(9, "sweep scrambled");
    sweep_round(3, "sweep scrambled b");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule